// File: doc/BRIEF.md
# Manchester II Word Decoder

This block receives one serial word coded in Manchester II and turns it back into data. The line comes in either as a single unipolar level or as a pair of complementary bipolar lines. The block takes samples of the line on every clock, at twelve samples per bit. It searches for a sync pattern three bit times long that has no mid-bit transition, and it takes its bit timing from the centre edge of that sync. It records whether the sync was of command type (high first) or data type (low first).

After a sync is accepted, the block decodes sixteen data bits and one parity bit. Each data bit goes out on a serial output with a one-cycle shift pulse. A take-data window covers those sixteen shifts. When the word is complete, a one-bit-time valid pulse follows, but only if every bit had a proper mid-bit transition and the parity over the seventeen bits is odd. A bad bit, a completed word or a decoder reset all send the block back to sync search. Successive words are assumed to be separated by at least two bit times of idle line.

Top module: `manch_word_rx`

## Requirements
- R1: When sel_unipolar=1 the line level is uni_in. When sel_unipolar=0 the level is 1 for bp_one_in=1 with bp_zero_in=0, and 0 for bp_one_in=0 with bp_zero_in=1. When both pair inputs are equal, the previous level is held.
- R2: A sync is accepted when the line holds one level for 17 to 19 samples and then the opposite level for at least 17 samples. A first run of 16 or 20 samples, or a second run of 16 samples, is rejected and produces no output activity.
- R3: cmd_sync is 1 after a high-first sync and 0 after a low-first sync. It changes only when a sync is accepted and keeps its value through rejected syncs, decoder resets and the whole word.
- R4: Each bit takes the level of its first half (high then low is a 1). The 16 data bits appear on ser_data, most significant first, each with a one-cycle shift_clk pulse.
- R5: The first shift_clk pulse comes 28 clock edges after the edge that registers the first sample of the sync's second level. Later pulses follow every 12 cycles.
- R6: take_data is high for exactly 192 cycles per good word, from the first shift pulse up to the cycle before the parity result. Every shift_clk pulse falls inside this window.
- R7: The parity bit makes the count of ones over the 17 bits odd. When it does, word_valid is high for exactly 12 cycles, starting 12 cycles after the last data shift pulse. When it does not, word_valid stays low.
- R8: A bit whose two half-cell samples are equal produces no shift pulse, ends take_data and prevents word_valid.
- R9: A dec_reset sampled high at a clock edge forces take_data, shift_clk and word_valid low after that edge and abandons the word.
- R10: While rst_n is low, all outputs are 0 after each clock edge, including cmd_sync.
- R11: After a word, an error or a decoder reset, the block returns to sync search and decodes the next word normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 12 per bit |
| rst_n | input | 1 | Synchronous active-low master reset |
| dec_reset | input | 1 | Synchronous decoder abort, active high |
| sel_unipolar | input | 1 | 1 selects uni_in, 0 selects the bipolar pair |
| uni_in | input | 1 | Unipolar line input |
| bp_one_in | input | 1 | Bipolar positive-level input |
| bp_zero_in | input | 1 | Bipolar negative-level input |
| ser_data | output | 1 | Decoded data bit |
| shift_clk | output | 1 | One-cycle pulse per decoded data bit |
| take_data | output | 1 | High across the 16 data shifts |
| word_valid | output | 1 | One-bit-time pulse for a good word |
| cmd_sync | output | 1 | Type of the last accepted sync, 1 = command |

## Verification
The bench builds the block with its default values: 12 samples per bit, 16 data bits and a sync tolerance of one sample. With these values a full 17-bit word and both tolerance edges of the sync (17 and 19 samples, plus the rejected 16 and 20) can be reached in a few hundred cycles. Random words mix both line modes, both sync types, good and bad parity, and bipolar hold samples. Directed words place a Manchester error at the first data bit, at a middle bit and at the parity bit, and place a decoder reset in the middle of the data field.

// File: rtl/mwr_pkg.sv
// Shared types for the Manchester word receiver.
// Assumes: one sample per clock and a fixed number of samples per bit.
package mwr_pkg;

    // Decoder phases: searching, checking the second half of sync, bits.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_BITS    = 2'd2
    } mwr_state_t;

    // One decided bit: a strobe, its value and a malformed flag.
    typedef struct packed {
        logic strobe;
        logic value;
        logic bad;
    } mwr_bit_t;

endpackage

// File: rtl/mwr_line_front.sv
// Line front end: turns the unipolar input or the bipolar pair into one
// registered level. Assumes the inputs are already synchronous to clk.
// If both pair inputs are equal, the last level is kept.
module mwr_line_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_unipolar,
    input  logic uni_in,
    input  logic bp_one_in,
    input  logic bp_zero_in,
    output logic line_q
);

    logic pair_defined;

    // A pair is meaningful only when exactly one input is asserted.
    always_comb pair_defined = bp_one_in ^ bp_zero_in;

    // Register the selected level; hold it on an undefined pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (sel_unipolar) begin
            line_q <= uni_in;
        end else if (pair_defined) begin
            line_q <= bp_one_in;
        end
    end

endmodule

// File: rtl/mwr_run_tracker.sv
// Run-length tracker: measures how long the line stays at one level.
// When the line changes level after a run that is 1.5 bit times long
// (within a tolerance), it flags a sync candidate.
// Assumes SPB is even, so that 1.5 bit times is a whole number of samples.
module mwr_run_tracker #(
    parameter int SPB = 12,
    parameter int TOL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_q,
    output logic sync_hit,
    output logic sync_first
);

    localparam int SYNC_LEN = (3 * SPB) / 2;
    localparam int RUN_MAX  = SYNC_LEN + TOL + 1;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);

    logic             last_q;
    logic [RUN_W-1:0] run_len;
    logic             line_edge;

    // The line changed level between the last two samples.
    always_comb line_edge = line_q ^ last_q;

    // Keep the previous sample and a saturating count of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            run_len <= '0;
        end else begin
            last_q <= line_q;
            if (line_edge) begin
                run_len <= RUN_W'(1);
            end else if (run_len != RUN_W'(RUN_MAX)) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // A finished run inside the tolerance window marks a sync centre.
    always_comb begin
        sync_hit = line_edge
                && (run_len >= RUN_W'(SYNC_LEN - TOL))
                && (run_len <= RUN_W'(SYNC_LEN + TOL));
        sync_first = last_q;
    end

endmodule

// File: rtl/mwr_bit_slicer.sv
// Bit slicer: while enabled, counts the sample phase within a bit cell.
// It captures the first half near its centre and decides the bit near the
// centre of the second half. Assumes phase 0 is the first sample of a cell.
module mwr_bit_slicer
    import mwr_pkg::*;
#(
    parameter int SPB = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     line_q,
    output mwr_bit_t bit_o
);

    localparam int PH_W      = $clog2(SPB);
    localparam int FIRST_AT  = SPB / 4;
    localparam int SECOND_AT = (3 * SPB) / 4;

    logic [PH_W-1:0] ph;
    logic            half1;

    // Phase counter within a cell; held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph <= '0;
        end else if (ph == PH_W'(SPB - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    // Capture the first-half level at its centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half1 <= 1'b0;
        end else if (en && (ph == PH_W'(FIRST_AT))) begin
            half1 <= line_q;
        end
    end

    // Decide the bit at the centre of the second half.
    always_comb begin
        bit_o.strobe = en && (ph == PH_W'(SECOND_AT));
        bit_o.value  = half1;
        bit_o.bad    = (half1 == line_q);
    end

endmodule

// File: rtl/mwr_word_ctrl.sv
// Word controller: confirms the second half of sync, then turns decided
// bits into shift pulses, the take-data window, the parity verdict and the
// sync type. Assumes a bit_i strobe once per cell while slice_en is high.
module mwr_word_ctrl
    import mwr_pkg::*;
#(
    parameter int SPB       = 12,
    parameter int DATA_BITS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dec_reset,
    input  logic     line_q,
    input  logic     sync_hit,
    input  logic     sync_first,
    input  mwr_bit_t bit_i,
    output logic     slice_en,
    output logic     ser_data,
    output logic     shift_clk,
    output logic     take_data,
    output logic     word_valid,
    output logic     cmd_sync
);

    localparam int SYNC_LEN = (3 * SPB) / 2;
    localparam int POS_W    = $clog2(SYNC_LEN + 1);
    localparam int IDX_W    = $clog2(DATA_BITS + 1);
    localparam int VC_W     = $clog2(SPB + 1);

    mwr_state_t       state;
    logic [POS_W-1:0] pos;
    logic             kind;
    logic [IDX_W-1:0] idx;
    logic             par;
    logic [VC_W-1:0]  vcnt;
    logic             confirm_done;

    // The second sync half has lasted long enough to start the bits.
    always_comb confirm_done = (state == ST_CONFIRM) && (pos == POS_W'(SYNC_LEN - 1));

    // Enable the slicer only in the bit phase.
    always_comb slice_en = (state == ST_BITS);

    // The valid pulse lasts as long as its down-counter is non-zero.
    always_comb word_valid = (vcnt != '0);

    // Sequence through hunt, confirm and bits, and drive the data outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || dec_reset) begin
            state     <= ST_HUNT;
            pos       <= '0;
            kind      <= 1'b0;
            idx       <= '0;
            par       <= 1'b0;
            ser_data  <= 1'b0;
            shift_clk <= 1'b0;
            take_data <= 1'b0;
            vcnt      <= '0;
        end else begin
            shift_clk <= 1'b0;
            if (vcnt != '0) begin
                vcnt <= vcnt - 1'b1;
            end
            unique case (state)
                ST_HUNT: begin
                    if (sync_hit) begin
                        state <= ST_CONFIRM;
                        pos   <= POS_W'(1);
                        kind  <= sync_first;
                    end
                end
                ST_CONFIRM: begin
                    if (confirm_done) begin
                        state <= ST_BITS;
                        idx   <= '0;
                        par   <= 1'b0;
                    end else if (line_q == kind) begin
                        state <= ST_HUNT;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (bit_i.strobe) begin
                        if (bit_i.bad) begin
                            state     <= ST_HUNT;
                            take_data <= 1'b0;
                        end else if (idx < IDX_W'(DATA_BITS)) begin
                            ser_data  <= bit_i.value;
                            shift_clk <= 1'b1;
                            take_data <= 1'b1;
                            par       <= par ^ bit_i.value;
                            idx       <= idx + 1'b1;
                        end else begin
                            state     <= ST_HUNT;
                            take_data <= 1'b0;
                            if (par ^ bit_i.value) begin
                                vcnt <= VC_W'(SPB);
                            end
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Latch the sync type when the sync is confirmed; only master reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sync <= 1'b0;
        end else if (!dec_reset && confirm_done) begin
            cmd_sync <= kind;
        end
    end

endmodule

// File: rtl/manch_word_rx.sv
// Manchester II word receiver top. It connects the line front end, the
// run-length sync finder, the bit slicer and the word controller.
// Assumes one clock per line sample at SPB samples per bit.
module manch_word_rx
    import mwr_pkg::*;
#(
    parameter int SPB       = 12,
    parameter int DATA_BITS = 16,
    parameter int SYNC_TOL  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_reset,
    input  logic sel_unipolar,
    input  logic uni_in,
    input  logic bp_one_in,
    input  logic bp_zero_in,
    output logic ser_data,
    output logic shift_clk,
    output logic take_data,
    output logic word_valid,
    output logic cmd_sync
);

    logic     line_q;
    logic     sync_hit;
    logic     sync_first;
    logic     slice_en;
    mwr_bit_t bit_w;

    mwr_line_front u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_unipolar (sel_unipolar),
        .uni_in       (uni_in),
        .bp_one_in    (bp_one_in),
        .bp_zero_in   (bp_zero_in),
        .line_q       (line_q)
    );

    mwr_run_tracker #(.SPB(SPB), .TOL(SYNC_TOL)) u_runs (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_q     (line_q),
        .sync_hit   (sync_hit),
        .sync_first (sync_first)
    );

    mwr_bit_slicer #(.SPB(SPB)) u_slicer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (slice_en),
        .line_q (line_q),
        .bit_o  (bit_w)
    );

    mwr_word_ctrl #(.SPB(SPB), .DATA_BITS(DATA_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_reset  (dec_reset),
        .line_q     (line_q),
        .sync_hit   (sync_hit),
        .sync_first (sync_first),
        .bit_i      (bit_w),
        .slice_en   (slice_en),
        .ser_data   (ser_data),
        .shift_clk  (shift_clk),
        .take_data  (take_data),
        .word_valid (word_valid),
        .cmd_sync   (cmd_sync)
    );

endmodule

// File: rtl/mwr_chk.sv
// Protocol checker for manch_word_rx: relates its outputs over time.
// Assumes it is bound to the top so that it sees the top's ports.
module mwr_chk #(
    parameter int SPB = 12
) (
    input logic clk,
    input logic rst_n,
    input logic dec_reset,
    input logic shift_clk,
    input logic take_data,
    input logic word_valid,
    input logic cmd_sync
);

    localparam int CW = $clog2(SPB + 2) + 1;

    logic [CW-1:0] gap;
    logic [CW-1:0] vlen;

    // Cycles since the last shift pulse inside the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !take_data) begin
            gap <= '0;
        end else if (shift_clk) begin
            gap <= CW'(1);
        end else if ((gap != '0) && (gap != '1)) begin
            gap <= gap + 1'b1;
        end
    end

    // Number of cycles that word_valid has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !word_valid) begin
            vlen <= '0;
        end else if (vlen != '1) begin
            vlen <= vlen + 1'b1;
        end
    end

    assert_shift_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_clk && (gap != '0)) |-> (gap == CW'(SPB)));

    assert_shift_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> take_data);

    assert_valid_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !take_data);

    assert_valid_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (vlen < CW'(SPB)));

    assert_sync_type_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |-> $stable(cmd_sync));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_reset |=> (!take_data && !shift_clk && !word_valid));

    assert_master_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!take_data && !shift_clk && !word_valid && !cmd_sync));

endmodule

bind manch_word_rx mwr_chk #(.SPB(SPB)) u_mwr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_reset  (dec_reset),
    .shift_clk  (shift_clk),
    .take_data  (take_data),
    .word_valid (word_valid),
    .cmd_sync   (cmd_sync)
);

// File: tb/manch_word_rx_bench.sv
module manch_word_rx_bench;

    logic clk = 1'b0;
    logic rst_n, dec_reset, sel_unipolar, uni_in, bp_one_in, bp_zero_in;
    logic ser_data, shift_clk, take_data, word_valid, cmd_sync;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // observation state for one word
    int nshift, ntake, in_take, nvalid, first_cyc, last_shift, vrise;
    logic [15:0] word_got;
    int samp_idx, rst_at, run_start;
    bit prev_rst;

    manch_word_rx u_manch_word_rx (
        .clk(clk), .rst_n(rst_n), .dec_reset(dec_reset),
        .sel_unipolar(sel_unipolar), .uni_in(uni_in),
        .bp_one_in(bp_one_in), .bp_zero_in(bp_zero_in),
        .ser_data(ser_data), .shift_clk(shift_clk), .take_data(take_data),
        .word_valid(word_valid), .cmd_sync(cmd_sync)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic logic parity_bit(input logic [15:0] d, input bit good);
        return good ? ~(^d) : (^d);
    endfunction

    task automatic clear_obs();
        nshift = 0; ntake = 0; in_take = 0; nvalid = 0;
        first_cyc = -1; last_shift = -1; vrise = -1;
        word_got = '0; samp_idx = 0; rst_at = -1; prev_rst = 0;
    endtask

    // sample the outputs at a falling edge
    task automatic observe();
        if (prev_rst) begin
            chk(!take_data && !shift_clk, "R9 abort next edge", int'(take_data), 0);
        end
        if (shift_clk) begin
            nshift++;
            word_got = {word_got[14:0], ser_data};
            if (first_cyc < 0) first_cyc = cyc;
            last_shift = cyc;
            if (take_data) in_take++;
        end
        if (take_data) ntake++;
        if (word_valid) begin
            nvalid++;
            if (vrise < 0) vrise = cyc;
        end
    endtask

    // drive n samples of one level, sampling outputs before each drive
    task automatic put(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            observe();
            if (i == 0) run_start = cyc + 1;
            uni_in = lvl;
            if (!sel_unipolar && (i > 0) && ($urandom % 4 == 0)) begin
                bp_one_in = 1'b0; bp_zero_in = 1'b0;   // R1 hold sample
            end else begin
                bp_one_in = lvl; bp_zero_in = ~lvl;
            end
            dec_reset = (samp_idx == rst_at);
            prev_rst = dec_reset;
            samp_idx++;
        end
    endtask

    task automatic send_word(input logic first, input logic [15:0] data, input bit par_ok,
                             input int l1, input int l2, input int err_bit, input int rstat);
        int t0;
        logic b, last;
        bit stop;
        clear_obs();
        rst_at = rstat;
        put(~first, 30);
        put(first, l1);
        put(~first, l2);
        t0 = run_start;
        stop = 0;
        last = ~first;
        for (int k = 0; k < 17; k++) begin
            if (!stop) begin
                b = (k < 16) ? data[15-k] : parity_bit(data, par_ok);
                if (k == err_bit) begin
                    put(b, 12); last = b; stop = 1;
                end else begin
                    put(b, 6); put(~b, 6); last = ~b;
                end
            end
        end
        put(last, 30);
        if (err_bit >= 0) begin
            chk(nshift == err_bit, "R8 shifts before bad bit", nshift, err_bit);
            chk(ntake == 12 * err_bit, "R8 window ends at bad bit", ntake, 12 * err_bit);
            chk(nvalid == 0, "R8 no valid", nvalid, 0);
        end else if (rstat >= 0) begin
            chk(nshift < 16, "R9 word abandoned", nshift, 15);
            chk(nvalid == 0, "R9 no valid", nvalid, 0);
            chk(ntake > 0, "R9 window had opened", ntake, 1);
        end else begin
            chk(nshift == 16, sel_unipolar ? "R4 R1 unipolar count" : "R4 R1 bipolar count", nshift, 16);
            chk(word_got == data, "R4 data", int'(word_got), int'(data));
            chk(first_cyc == t0 + 28, "R5 first shift", first_cyc, t0 + 28);
            chk(last_shift == t0 + 208, "R5 last shift", last_shift, t0 + 208);
            chk(ntake == 192, "R6 window length", ntake, 192);
            chk(in_take == 16, "R6 shifts inside window", in_take, 16);
            chk(nvalid == (par_ok ? 12 : 0), "R7 R11 valid length", nvalid, par_ok ? 12 : 0);
            if (par_ok) chk(vrise == last_shift + 12, "R7 valid start", vrise, last_shift + 12);
            chk(cmd_sync == first, "R3 sync type", int'(cmd_sync), int'(first));
        end
    endtask

    task automatic bad_sync(input logic first, input int l1, input int l2);
        logic keep;
        keep = cmd_sync;
        clear_obs();
        put(~first, 30);
        put(first, l1);
        put(~first, l2);
        put(first, 30);
        chk(nshift == 0 && ntake == 0, "R2 rejected sync silent", nshift + ntake, 0);
        chk(nvalid == 0, "R2 rejected sync no valid", nvalid, 0);
        chk(cmd_sync == keep, "R3 type kept on reject", int'(cmd_sync), int'(keep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R11 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1553));
        rst_n = 0; dec_reset = 0; sel_unipolar = 1; uni_in = 0; bp_one_in = 0; bp_zero_in = 1;
        repeat (3) @(negedge clk);
        chk(!ser_data && !shift_clk && !take_data && !word_valid && !cmd_sync,
            "R10 reset outputs", int'({ser_data, shift_clk, take_data, word_valid, cmd_sync}), 0);
        rst_n = 1;
        clear_obs();
        put(1'b0, 40);

        // directed corners
        send_word(1'b1, 16'hA5C3, 1, 18, 18, -1, -1);
        sel_unipolar = 0;
        send_word(1'b0, 16'h0000, 1, 18, 18, -1, -1);
        send_word(1'b1, 16'hFFFF, 1, 17, 18, -1, -1);   // R2 low edge
        send_word(1'b0, 16'h8001, 1, 19, 17, -1, -1);   // R2 high edge
        bad_sync(1'b1, 16, 30);
        bad_sync(1'b0, 20, 30);
        bad_sync(1'b1, 18, 16);
        sel_unipolar = 1;
        send_word(1'b1, 16'h1234, 0, 18, 18, -1, -1);   // bad parity
        send_word(1'b0, 16'h5A5A, 1, 18, 18, 0, -1);
        send_word(1'b1, 16'h5A5A, 1, 18, 18, 5, -1);
        send_word(1'b0, 16'hC0DE, 1, 18, 18, 16, -1);
        send_word(1'b1, 16'h7E81, 1, 18, 18, -1, 150);
        send_word(1'b0, 16'h7E81, 1, 18, 18, -1, -1);  // R11 recovery
        send_word(1'b1, 16'h0F0F, 1, 18, 18, -1, -1);

        // master reset clears the sync type
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        chk(cmd_sync == 1'b0 && !take_data && !word_valid, "R10 mid-run reset", int'(cmd_sync), 0);
        rst_n = 1;
        clear_obs();
        put(1'b0, 40);

        // random words
        for (int w = 0; w < 40; w++) begin
            logic [15:0] d;
            logic f;
            bit pok;
            d = 16'($urandom);
            f = 1'($urandom);
            pok = ($urandom % 5) != 0;
            sel_unipolar = 1'($urandom);
            send_word(f, d, pok, 17 + int'($urandom % 3), 17 + int'($urandom % 2), -1, -1);
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule